// File: doc/BRIEF.md
# Lockable System Control Registers

A small register file for board-level control, reached over a 32-bit word bus. It has a software lock, two flag words, a reset-control word and a bank of oscillator setting words. The lock is opened only by writing one exact 32-bit key. While the lock is open, the oscillator words and the reset-control word accept writes. Any other lock value keeps them shut.

Each flag word has its own read/set address and its own clear address. Firmware can therefore change individual bits without a read-modify-write. An accepted write to reset control does three things: it latches a reset level, it emits a one-cycle board-reset request, and it wipes the volatile flags. The non-volatile flags survive that request.

Every request is answered one cycle later. The response carries the read data and an error strobe. The error strobe flags offsets that are not mapped, offsets that are not word-aligned, and reads of write-only addresses.

Top module: `sysctl_regs`

## Requirements
- R1: After synchronous reset, the lock reads 0x0001_0000 (locked, stored value zero), and the flags, non-volatile flags, reset level and every oscillator word read zero. No reset request is raised.
- R2: A request accepted on a clock edge gives rsp_valid high for exactly the following cycle. Read data shows the state before that request, and write responses carry zero data.
- R3: Writing exactly 0x0000_A05F to offset 0x20 opens the lock. Reading 0x20 then returns 0x0000_A05F, with bit 16 clear.
- R4: Writing any other 32-bit value to 0x20 stores only bits 14:0 of it and closes the lock. Reading 0x20 returns that value with bit 16 set.
- R5: Writing offset 0x30 ORs the data into the flags. Writing 0x34 clears the bits set to 1 in the data. Reading 0x30 returns the flags.
- R6: Writing offset 0x38 ORs the data into the non-volatile flags. Writing 0x3C clears the bits set to 1 in the data. Reading 0x38 returns them.
- R7: While unlocked, a write to 0x40 does four things. It stores data bits 7:0 as the reset level, readable at 0x40. It raises board_rst_req for the single response cycle. It clears the flags. It leaves the non-volatile flags and the lock unchanged.
- R8: While locked, a write to 0x40 changes nothing and raises no reset request.
- R9: The oscillator words sit at 0x0C + 4*i for i = 0..NUM_OSC-1. Each is written only while unlocked, and writes while locked are ignored. All of them read back at the same address.
- R10: These accesses raise rsp_err for one cycle with zero read data and change no state: an unmapped offset, an offset with bits 1:0 non-zero, and a read of 0x34 or 0x3C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one transfer per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | DATA_W | Read data, zero for writes and errors |
| rsp_err | output | 1 | Bad-access strobe |
| board_rst_req | output | 1 | One-cycle board reset request |

## Verification
The assertions take two things for granted. The first is that req_valid and the request fields are held low or stable while rst is high. The second is that only one request is presented per cycle, so a set and a clear of the same flag word never coincide. The stimulus drives every field on the falling edge and keeps req_valid low during reset. It issues exactly one transfer per cycle, as back-to-back or isolated requests, so each response can be tied to a single request.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int unsigned OFF_OSC_BASE = 32'h0C;
    localparam int unsigned OFF_LOCK     = 32'h20;
    localparam int unsigned OFF_FLAGS    = 32'h30;
    localparam int unsigned OFF_FLAGS_CL = 32'h34;
    localparam int unsigned OFF_NV       = 32'h38;
    localparam int unsigned OFF_NV_CL    = 32'h3C;
    localparam int unsigned OFF_RSTCTL   = 32'h40;

    localparam logic [31:0] UNLOCK_KEY   = 32'h0000_A05F;
    localparam int unsigned LOCK_KEEP_W  = 15;
    localparam int unsigned LOCK_W       = 16;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_OSC,
        SEL_LOCK,
        SEL_FLAGS,
        SEL_FLAGS_CLR,
        SEL_NV,
        SEL_NV_CLR,
        SEL_RSTCTL
    } sel_e;

    function automatic logic [LOCK_W-1:0] lock_next(input logic [31:0] wd);
        if (wd == UNLOCK_KEY)
            return UNLOCK_KEY[LOCK_W-1:0];
        return {1'b0, wd[LOCK_KEEP_W-1:0]};
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_OSC   = 5,
    parameter int OSC_IDX_W = 3
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 is_write,
    output sel_e                 sel,
    output logic [OSC_IDX_W-1:0] osc_idx
);
    localparam logic [ADDR_W-1:0] A_LOCK   = ADDR_W'(OFF_LOCK);
    localparam logic [ADDR_W-1:0] A_FLAGS  = ADDR_W'(OFF_FLAGS);
    localparam logic [ADDR_W-1:0] A_FLGCL  = ADDR_W'(OFF_FLAGS_CL);
    localparam logic [ADDR_W-1:0] A_NV     = ADDR_W'(OFF_NV);
    localparam logic [ADDR_W-1:0] A_NVCL   = ADDR_W'(OFF_NV_CL);
    localparam logic [ADDR_W-1:0] A_RSTCTL = ADDR_W'(OFF_RSTCTL);

    always_comb begin
        sel     = SEL_NONE;
        osc_idx = '0;
        for (int i = 0; i < NUM_OSC; i++) begin
            if (addr == ADDR_W'(OFF_OSC_BASE + 4 * i)) begin
                sel     = SEL_OSC;
                osc_idx = OSC_IDX_W'(i);
            end
        end
        if (addr == A_LOCK)   sel = SEL_LOCK;
        if (addr == A_FLAGS)  sel = SEL_FLAGS;
        if (addr == A_NV)     sel = SEL_NV;
        if (addr == A_RSTCTL) sel = SEL_RSTCTL;
        // clear addresses are write-only; a read of them is a bad access
        if (addr == A_FLGCL && is_write) sel = SEL_FLAGS_CLR;
        if (addr == A_NVCL  && is_write) sel = SEL_NV_CLR;
    end
endmodule

// File: rtl/sysctl_setclr.sv
module sysctl_setclr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic         wipe,
    input  logic [W-1:0] bits,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || wipe) q <= '0;
        else if (clr_en) q <= q & ~bits;
        else if (set_en) q <= q | bits;
    end

    AST_SET_RAISES: assert property (@(posedge clk) disable iff (rst)
        (set_en && !clr_en && !wipe) |=> ((q & $past(bits)) == $past(bits))); // R5
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !wipe) |=> ((q & $past(bits)) == '0)); // R6
endmodule

// File: rtl/sysctl_lock.sv
module sysctl_lock
    import sysctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic        unlocked,
    output logic [31:0] rd_word
);
    logic [LOCK_W-1:0] lock_q;

    always_ff @(posedge clk) begin
        if (rst)        lock_q <= '0;
        else if (wr_en) lock_q <= lock_next(wdata);
    end

    assign unlocked = (lock_q == UNLOCK_KEY[LOCK_W-1:0]);
    assign rd_word  = {15'd0, ~unlocked, lock_q};

    AST_KEY_OPENS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata == UNLOCK_KEY) |=> unlocked); // R3
    AST_OTHER_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata != UNLOCK_KEY) |=> !unlocked); // R4
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int NUM_OSC  = 5,
    parameter int RSTLVL_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              board_rst_req
);
    localparam int OSC_IDX_W = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1;

    sel_e                 sel;
    logic [OSC_IDX_W-1:0] osc_idx;
    logic                 hit, wr_ok, rd_ok;
    logic                 unlocked;
    logic [31:0]          lock_rd;
    logic [DATA_W-1:0]    flags_q, nv_q, rd_mux;
    logic [RSTLVL_W-1:0]  rst_lvl_q;
    logic [DATA_W-1:0]    osc_q [NUM_OSC];
    logic                 rstctl_go;

    sysctl_decode #(.ADDR_W(ADDR_W), .NUM_OSC(NUM_OSC), .OSC_IDX_W(OSC_IDX_W)) u_dec (
        .addr(req_addr), .is_write(req_write), .sel(sel), .osc_idx(osc_idx)
    );

    assign hit       = (sel != SEL_NONE);
    assign wr_ok     = req_valid && req_write && hit;
    assign rd_ok     = req_valid && !req_write && hit;
    assign rstctl_go = wr_ok && (sel == SEL_RSTCTL) && unlocked;

    sysctl_lock u_lock (
        .clk(clk), .rst(rst),
        .wr_en(wr_ok && sel == SEL_LOCK),
        .wdata(req_wdata[31:0]),
        .unlocked(unlocked), .rd_word(lock_rd)
    );

    sysctl_setclr #(.W(DATA_W)) u_flags (
        .clk(clk), .rst(rst),
        .set_en(wr_ok && sel == SEL_FLAGS),
        .clr_en(wr_ok && sel == SEL_FLAGS_CLR),
        .wipe(rstctl_go), .bits(req_wdata), .q(flags_q)
    );

    sysctl_setclr #(.W(DATA_W)) u_nv (
        .clk(clk), .rst(rst),
        .set_en(wr_ok && sel == SEL_NV),
        .clr_en(wr_ok && sel == SEL_NV_CLR),
        .wipe(1'b0), .bits(req_wdata), .q(nv_q)
    );

    for (genvar i = 0; i < NUM_OSC; i++) begin : g_osc
        always_ff @(posedge clk) begin
            if (rst)
                osc_q[i] <= '0;
            else if (wr_ok && sel == SEL_OSC && unlocked && osc_idx == OSC_IDX_W'(i))
                osc_q[i] <= req_wdata;
        end

        AST_OSC_LOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
            !unlocked |=> $stable(osc_q[i])); // R9
    end

    always_ff @(posedge clk) begin
        if (rst)            rst_lvl_q <= '0;
        else if (rstctl_go) rst_lvl_q <= req_wdata[RSTLVL_W-1:0];
    end

    always_comb begin
        case (sel)
            SEL_OSC:    rd_mux = osc_q[osc_idx];
            SEL_LOCK:   rd_mux = DATA_W'(lock_rd);
            SEL_FLAGS:  rd_mux = flags_q;
            SEL_NV:     rd_mux = nv_q;
            SEL_RSTCTL: rd_mux = DATA_W'(rst_lvl_q);
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid     <= 1'b0;
            rsp_err       <= 1'b0;
            rsp_rdata     <= '0;
            board_rst_req <= 1'b0;
        end else begin
            rsp_valid     <= req_valid;
            rsp_err       <= req_valid && !hit;
            rsp_rdata     <= rd_ok ? rd_mux : '0;
            board_rst_req <= rstctl_go;
        end
    end

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R2
    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R2
    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && rsp_rdata == '0)); // R10
    AST_PULSE_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
        board_rst_req |-> $past(unlocked)); // R8
    AST_PULSE_KEEPS_NV: assert property (@(posedge clk) disable iff (rst)
        rstctl_go |=> $stable(nv_q)); // R7
endmodule

// File: tb/sysctl_regs_tb.sv
`timescale 1ns/1ps
module sysctl_regs_tb;
    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic        err;
        logic        pls;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 42;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h020, 32'h0,          32'h0001_0000, 1'b0, 1'b0, 8'd1},  // R1
        '{1'b0, 12'h030, 32'h0,          32'h0,         1'b0, 1'b0, 8'd1},  // R1
        '{1'b0, 12'h038, 32'h0,          32'h0,         1'b0, 1'b0, 8'd1},  // R1
        '{1'b0, 12'h040, 32'h0,          32'h0,         1'b0, 1'b0, 8'd1},  // R1
        '{1'b0, 12'h00C, 32'h0,          32'h0,         1'b0, 1'b0, 8'd1},  // R1
        '{1'b1, 12'h00C, 32'h1234_5678,  32'h0,         1'b0, 1'b0, 8'd9},  // R9
        '{1'b0, 12'h00C, 32'h0,          32'h0,         1'b0, 1'b0, 8'd9},  // R9
        '{1'b1, 12'h040, 32'h55,         32'h0,         1'b0, 1'b0, 8'd8},  // R8
        '{1'b0, 12'h040, 32'h0,          32'h0,         1'b0, 1'b0, 8'd8},  // R8
        '{1'b1, 12'h020, 32'h0000_FFFF,  32'h0,         1'b0, 1'b0, 8'd4},  // R4
        '{1'b0, 12'h020, 32'h0,          32'h0001_7FFF, 1'b0, 1'b0, 8'd4},  // R4
        '{1'b1, 12'h020, 32'h0001_A05F,  32'h0,         1'b0, 1'b0, 8'd4},  // R4
        '{1'b0, 12'h020, 32'h0,          32'h0001_205F, 1'b0, 1'b0, 8'd4},  // R4
        '{1'b1, 12'h020, 32'h0000_A05F,  32'h0,         1'b0, 1'b0, 8'd3},  // R3
        '{1'b0, 12'h020, 32'h0,          32'h0000_A05F, 1'b0, 1'b0, 8'd3},  // R3
        '{1'b1, 12'h030, 32'hF0,         32'h0,         1'b0, 1'b0, 8'd5},  // R5
        '{1'b1, 12'h030, 32'h03,         32'h0,         1'b0, 1'b0, 8'd5},  // R5
        '{1'b0, 12'h030, 32'h0,          32'hF3,        1'b0, 1'b0, 8'd5},  // R5
        '{1'b1, 12'h034, 32'h11,         32'h0,         1'b0, 1'b0, 8'd5},  // R5
        '{1'b0, 12'h030, 32'h0,          32'hE2,        1'b0, 1'b0, 8'd5},  // R5
        '{1'b1, 12'h038, 32'hA00A,       32'h0,         1'b0, 1'b0, 8'd6},  // R6
        '{1'b1, 12'h03C, 32'h02,         32'h0,         1'b0, 1'b0, 8'd6},  // R6
        '{1'b0, 12'h038, 32'h0,          32'hA008,      1'b0, 1'b0, 8'd6},  // R6
        '{1'b1, 12'h01C, 32'hCAFE_0004,  32'h0,         1'b0, 1'b0, 8'd9},  // R9
        '{1'b0, 12'h01C, 32'h0,          32'hCAFE_0004, 1'b0, 1'b0, 8'd9},  // R9
        '{1'b1, 12'h010, 32'h1111_0001,  32'h0,         1'b0, 1'b0, 8'd9},  // R9
        '{1'b0, 12'h010, 32'h0,          32'h1111_0001, 1'b0, 1'b0, 8'd9},  // R9
        '{1'b0, 12'h034, 32'h0,          32'h0,         1'b1, 1'b0, 8'd10}, // R10
        '{1'b1, 12'h044, 32'hFFFF_FFFF,  32'h0,         1'b1, 1'b0, 8'd10}, // R10
        '{1'b0, 12'h031, 32'h0,          32'h0,         1'b1, 1'b0, 8'd10}, // R10
        '{1'b0, 12'h030, 32'h0,          32'hE2,        1'b0, 1'b0, 8'd10}, // R10
        '{1'b1, 12'h040, 32'h1A7,        32'h0,         1'b0, 1'b1, 8'd7},  // R7
        '{1'b0, 12'h040, 32'h0,          32'hA7,        1'b0, 1'b0, 8'd7},  // R7
        '{1'b0, 12'h030, 32'h0,          32'h0,         1'b0, 1'b0, 8'd7},  // R7
        '{1'b0, 12'h038, 32'h0,          32'hA008,      1'b0, 1'b0, 8'd7},  // R7
        '{1'b0, 12'h020, 32'h0,          32'h0000_A05F, 1'b0, 1'b0, 8'd7},  // R7
        '{1'b1, 12'h020, 32'h0,          32'h0,         1'b0, 1'b0, 8'd4},  // R4
        '{1'b1, 12'h040, 32'h3,          32'h0,         1'b0, 1'b0, 8'd8},  // R8
        '{1'b0, 12'h040, 32'h0,          32'hA7,        1'b0, 1'b0, 8'd8},  // R8
        '{1'b1, 12'h00C, 32'h5,          32'h0,         1'b0, 1'b0, 8'd9},  // R9
        '{1'b0, 12'h00C, 32'h0,          32'h0,         1'b0, 1'b0, 8'd9},  // R9
        '{1'b0, 12'h300, 32'h0,          32'h0,         1'b1, 1'b0, 8'd10}  // R10
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr  = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err, board_rst_req;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    sysctl_regs u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .board_rst_req(board_rst_req)
    );

    task automatic check(input int rq, input logic [34:0] act, input logic [34:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d: got {valid,err,pulse,data}=%h expected %h", rq, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        #1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            req_valid = 1'b1;
            req_write = VECS[i].wr;
            req_addr  = VECS[i].addr;
            req_wdata = VECS[i].wdata;
            @(posedge clk);
            #1;
            check(int'(VECS[i].req), {rsp_valid, rsp_err, board_rst_req, rsp_rdata},
                  {1'b1, VECS[i].err, VECS[i].pls, VECS[i].exp});
        end
        @(negedge clk) req_valid = 1'b0;
        @(posedge clk);
        #1;
        // R2: idle cycle gives no response and no pulse
        check(2, {rsp_valid, rsp_err, board_rst_req, rsp_rdata}, 35'h0);

        // R1: synchronous reset mid-run clears the lock, nv flags and osc words
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h020;
        @(posedge clk); #1;
        check(1, {rsp_valid, rsp_err, board_rst_req, rsp_rdata}, {3'b100, 32'h0001_0000});
        @(negedge clk) req_addr = 12'h038;
        @(posedge clk); #1;
        check(1, {rsp_valid, rsp_err, board_rst_req, rsp_rdata}, {3'b100, 32'h0});
        @(negedge clk) req_addr = 12'h01C;
        @(posedge clk); #1;
        check(1, {rsp_valid, rsp_err, board_rst_req, rsp_rdata}, {3'b100, 32'h0});
        @(negedge clk) req_valid = 1'b0;

        // R7: back-to-back unlocked reset-control writes each pulse
        xfer(1'b1, 12'h020, 32'h0000_A05F);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h040; req_wdata = 32'h12;
        @(posedge clk); #1;
        check(7, {rsp_valid, rsp_err, board_rst_req, rsp_rdata}, {3'b101, 32'h0});
        @(negedge clk) req_wdata = 32'h34;
        @(posedge clk); #1;
        check(7, {rsp_valid, rsp_err, board_rst_req, rsp_rdata}, {3'b101, 32'h0});
        @(negedge clk) req_write = 1'b0;
        @(posedge clk); #1;
        check(7, {rsp_valid, rsp_err, board_rst_req, rsp_rdata}, {3'b100, 32'h34});
        @(negedge clk) req_valid = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule